// File: doc/BRIEF.md
# Three-Line Stereo Serial Audio Port with Input Routing

This block is the serial audio edge of a multichannel audio path. It acts as bus master. From the system clock it produces one bit clock and one frame (left/right) clock, and all three serial input lines and all three serial output lines share them. A frame is 64 bit clocks long, with 32 bit slots per channel. Each slot half carries one 24-bit two's-complement sample, MSB first.

On the receive side, each input line is turned into a left/right word pair. A routing setting then places each line's pair onto one of three logical channel pairs: front left/right, centre/subwoofer, or surround left/right. The routed set is presented once per frame with a one-cycle valid strobe.

On the transmit side, the three logical pairs always go out on fixed lines. Line 0 carries front, line 1 carries centre/sub and line 2 carries surround. One format setting chooses between the standard I2S framing, left-justified framing and right-justified framing, and both directions follow it.

The timing core is a two-state machine, with states PH_LO (bit clock low) and PH_HI (bit clock high).
- PH_LO to PH_HI is taken when the divider reaches its terminal count. This is the rising bit-clock edge, and all inputs are sampled on it.
- PH_HI to PH_LO is taken on the next terminal count. This is the falling bit-clock edge. On it the bit counter advances, and the frame clock and the data outputs are updated.

Top module: `aud_serial_router`

## Requirements
- R1: `bclk` is low after reset and toggles every CLK_DIV system clocks, so it has a 50 % duty cycle and a period of 2*CLK_DIV clocks.
- R2: A frame is 64 bit clocks: slots 0..31 carry the left channel and slots 32..63 the right channel. `lrclk` and `sdo` change only on falling `bclk` edges.
- R3: `fmt_sel` encoding is: 0 standard I2S, 1 left-justified, 2 right-justified, 3 behaves as 0. In I2S, `lrclk` is low during the left half. In both justified formats, `lrclk` is high during the left half.
- R4: Within a 32-slot half, the word is sent MSB first. In I2S it occupies slots 1..24. Left-justified uses slots 0..23. Right-justified uses slots 8..31, so bit 0 sits in the last slot before the `lrclk` edge. All other slots drive 0.
- R5: Each `sdi` line is sampled on rising `bclk` using the same slot map as R4. Levels in the unused slots are ignored.
- R6: `fmt_sel` is taken on the falling edge that starts slot 0 and holds for the whole frame in both directions. After reset the format is I2S.
- R7: `tx_word` is taken at the same frame boundary. Pair j (0 front, 1 centre/sub, 2 surround) has its left word at bits [48j+23:48j] and its right word at [48j+47:48j+24], and is sent on `sdo[j]`. The first frame after reset sends zeros.
- R8: `route_sel[2i+1:2i]` assigns input line i: 0 front pair, 1 centre/sub pair, 2 surround pair, 3 no pair. `rx_word` uses the R7 layout.
- R9: A pair that no line is assigned to reads as zero in `rx_word`.
- R10: If several lines are assigned to one pair, the line with the lowest number supplies it.
- R11: `rx_valid` is a single-clock pulse one system clock after the rising `bclk` of slot 63. `rx_word` updates only with that pulse, using `route_sel` at that moment, and holds otherwise.
- R12: In reset, `bclk`, `lrclk`, `sdo`, `rx_valid` and `rx_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing format for both directions |
| route_sel | input | 6 | Pair assignment, two bits per input line |
| tx_word | input | 144 | Words to transmit, three pairs of left/right |
| sdi | input | 3 | Serial data inputs |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (left/right) clock |
| sdo | output | 3 | Serial data outputs, one per fixed pair |
| rx_word | output | 144 | Routed received words, three pairs of left/right |
| rx_valid | output | 1 | One-clock strobe when a frame has been captured |

## Verification
The hardest situation to reach from the ports is a format change that lands in the middle of a frame. The old framing must finish that frame on both the receive and transmit side, and the new framing must start exactly at slot 0. The stimulus therefore switches `fmt_sel` and `tx_word` at slot 20 of a running frame. It then steps through all four format codes, so every possible transition of the frame clock across a frame boundary is covered, including the one where `lrclk` does not toggle at the boundary at all. The input lines drive 1 in every slot outside the word, so any misplaced sample point corrupts the captured data. The routing setting moves through a one-to-one map, a rotation, a map with two lines on one pair and a fully unassigned map. This exercises R9 and R10.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    // Position of a word bit inside a channel half, -1 when the slot is empty.
    function automatic int word_bit(input logic [1:0] fmt, input int slot,
                                    input int ww, input int sw);
        int r;
        r = -1;
        case (fmt)
            FMT_LEFT:  if (slot < ww) r = ww - 1 - slot;
            FMT_RIGHT: if (slot >= sw - ww) r = sw - 1 - slot;
            default:   if (slot >= 1 && slot <= ww) r = ww - slot;
        endcase
        return r;
    endfunction

    // Frame clock level for a given half of the frame.
    function automatic logic lr_level(input logic [1:0] fmt, input logic right_half);
        logic just;
        just = (fmt == FMT_LEFT) || (fmt == FMT_RIGHT);
        return just ? ~right_half : right_half;
    endfunction

endpackage

// File: rtl/asr_timing.sv
module asr_timing
    import asr_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int SLOT_W  = 32,
    localparam int BIT_W  = $clog2(2 * SLOT_W),
    localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_sel,
    output logic             bclk,
    output logic             lrclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             wrap,
    output logic [BIT_W-1:0] bitcnt,
    output logic [BIT_W-1:0] bit_nxt,
    output logic [1:0]       fmt_q,
    output logic [1:0]       fmt_nxt
);

    // SLOT_W must be a power of two so that the counter MSB marks the right half.
    localparam int LAST = 2 * SLOT_W - 1;

    logic [DIV_W-1:0] divcnt;
    logic             tick;
    phase_e           state, state_nxt;

    assign tick = (divcnt == DIV_W'(CLK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    divcnt <= '0;
        else if (tick) divcnt <= '0;
        else           divcnt <= divcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_LO: if (tick) state_nxt = PH_HI;
            PH_HI: if (tick) state_nxt = PH_LO;
        endcase
    end

    always_comb begin
        bclk     = (state == PH_HI);
        rise_stb = tick && (state == PH_LO);
        fall_stb = tick && (state == PH_HI);
    end

    assign wrap    = fall_stb && (bitcnt == BIT_W'(LAST));
    assign bit_nxt = (bitcnt == BIT_W'(LAST)) ? '0 : bitcnt + 1'b1;
    assign fmt_nxt = wrap ? fmt_sel : fmt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            fmt_q  <= FMT_I2S;
            lrclk  <= 1'b0;
        end else if (fall_stb) begin
            bitcnt <= bit_nxt;
            fmt_q  <= fmt_nxt;
            lrclk  <= lr_level(fmt_nxt, bit_nxt[BIT_W-1]);
        end
    end

endmodule

// File: rtl/asr_rx_lane.sv
module asr_rx_lane
    import asr_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SLOT_W  = 32,
    localparam int BIT_W  = $clog2(2 * SLOT_W),
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_stb,
    input  logic [BIT_W-1:0]  bitcnt,
    input  logic [1:0]        fmt_q,
    input  logic              sdi,
    output logic [PAIR_W-1:0] word
);

    int kpos;
    int base;

    always_comb begin
        kpos = word_bit(fmt_q, int'(bitcnt[BIT_W-2:0]), WORD_W, SLOT_W);
        base = bitcnt[BIT_W-1] ? WORD_W : 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (rise_stb) begin
            for (int k = 0; k < WORD_W; k++) begin
                if (kpos == k) word[base + k] <= sdi;
            end
        end
    end

endmodule

// File: rtl/asr_tx_lane.sv
module asr_tx_lane
    import asr_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SLOT_W  = 32,
    localparam int BIT_W  = $clog2(2 * SLOT_W),
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_stb,
    input  logic              wrap,
    input  logic [BIT_W-1:0]  bit_nxt,
    input  logic [1:0]        fmt_nxt,
    input  logic [PAIR_W-1:0] word_in,
    output logic              sdo
);

    logic [PAIR_W-1:0] shadow;
    logic [PAIR_W-1:0] src;
    logic              bit_val;
    int                kpos;

    assign src = wrap ? word_in : shadow;

    always_comb begin
        kpos    = word_bit(fmt_nxt, int'(bit_nxt[BIT_W-2:0]), WORD_W, SLOT_W);
        bit_val = 1'b0;
        for (int k = 0; k < WORD_W; k++) begin
            if (kpos == k) bit_val = bit_nxt[BIT_W-1] ? src[WORD_W + k] : src[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            sdo    <= 1'b0;
        end else if (fall_stb) begin
            if (wrap) shadow <= word_in;
            sdo <= bit_val;
        end
    end

endmodule

// File: rtl/asr_router.sv
module asr_router #(
    parameter int WORD_W  = 24,
    parameter int LINES   = 3,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int SEL_W  = 2
) (
    input  logic [LINES*SEL_W-1:0]  route_sel,
    input  logic [LINES*PAIR_W-1:0] lane_words,
    output logic [LINES*PAIR_W-1:0] pair_words
);

    always_comb begin
        pair_words = '0;
        for (int j = 0; j < LINES; j++) begin
            // Walk from the highest line down so the lowest match is written last.
            for (int i = LINES - 1; i >= 0; i--) begin
                if (route_sel[i*SEL_W +: SEL_W] == SEL_W'(j))
                    pair_words[j*PAIR_W +: PAIR_W] = lane_words[i*PAIR_W +: PAIR_W];
            end
        end
    end

endmodule

// File: rtl/aud_serial_router.sv
module aud_serial_router
    import asr_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int WORD_W  = 24,
    parameter int SLOT_W  = 32,
    localparam int LINES  = 3,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int BUS_W  = LINES * PAIR_W,
    localparam int BIT_W  = $clog2(2 * SLOT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         fmt_sel,
    input  logic [2*LINES-1:0] route_sel,
    input  logic [BUS_W-1:0]   tx_word,
    input  logic [LINES-1:0]   sdi,
    output logic               bclk,
    output logic               lrclk,
    output logic [LINES-1:0]   sdo,
    output logic [BUS_W-1:0]   rx_word,
    output logic               rx_valid
);

    localparam int LAST = 2 * SLOT_W - 1;

    logic             rise_stb, fall_stb, wrap;
    logic [BIT_W-1:0] bitcnt, bit_nxt;
    logic [1:0]       fmt_q, fmt_nxt;
    logic [BUS_W-1:0] lane_words, routed;
    logic             done_d;

    asr_timing #(.CLK_DIV(CLK_DIV), .SLOT_W(SLOT_W)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_sel  (fmt_sel),
        .bclk     (bclk),
        .lrclk    (lrclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .wrap     (wrap),
        .bitcnt   (bitcnt),
        .bit_nxt  (bit_nxt),
        .fmt_q    (fmt_q),
        .fmt_nxt  (fmt_nxt)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        asr_rx_lane #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_stb (rise_stb),
            .bitcnt   (bitcnt),
            .fmt_q    (fmt_q),
            .sdi      (sdi[g]),
            .word     (lane_words[g*PAIR_W +: PAIR_W])
        );

        asr_tx_lane #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .fall_stb (fall_stb),
            .wrap     (wrap),
            .bit_nxt  (bit_nxt),
            .fmt_nxt  (fmt_nxt),
            .word_in  (tx_word[g*PAIR_W +: PAIR_W]),
            .sdo      (sdo[g])
        );
    end

    asr_router #(.WORD_W(WORD_W), .LINES(LINES)) u_router (
        .route_sel  (route_sel),
        .lane_words (lane_words),
        .pair_words (routed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_d   <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            done_d   <= rise_stb && (bitcnt == BIT_W'(LAST));
            rx_valid <= done_d;
            if (done_d) rx_word <= routed;
        end
    end

endmodule

// File: rtl/asr_checker.sv
module asr_checker #(
    parameter int LINES = 3,
    parameter int RX_W  = 144
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             lrclk,
    input logic [LINES-1:0] sdo,
    input logic [RX_W-1:0]  rx_word,
    input logic             rx_valid
);

    // R2: frame clock moves only on a falling bit clock
    p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lrclk != $past(lrclk)) |-> (!bclk && $past(bclk)));

    // R2: data outputs move only on a falling bit clock
    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo != $past(sdo)) |-> (!bclk && $past(bclk)));

    // R11: strobe lasts one clock
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: received words hold between strobes
    p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (rx_word == $past(rx_word)));

    // R11: strobe follows a rising bit clock, so the bit clock is high before it
    p_valid_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk));

endmodule

bind aud_serial_router asr_checker u_asr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .lrclk    (lrclk),
    .sdo      (sdo),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
);

// File: tb/test_aud_serial_router.sv
module test_aud_serial_router;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int WW         = 24;
    localparam int SW         = 32;
    localparam int BUS        = 144;
    localparam int FRAME_CLKS = 128 * DIV;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      fmt_sel = 2'd0;
    logic [5:0]      route_sel = 6'b10_01_00;
    logic [BUS-1:0]  tx_word = '0;
    logic [2:0]      sdi = 3'b000;
    logic            bclk, lrclk, rx_valid;
    logic [2:0]      sdo;
    logic [BUS-1:0]  rx_word;

    int    checks = 0;
    int    errors = 0;
    bit    done_flag = 0;
    string rx_tag = "R5 R8";

    // reference model state
    int             m_n = 0;
    logic [1:0]     m_fmt = 2'd0;
    logic [BUS-1:0] m_tx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_serial_router #(.CLK_DIV(DIV)) i_aud_serial_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .route_sel (route_sel),
        .tx_word   (tx_word),
        .sdi       (sdi),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .sdo       (sdo),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    function automatic int slot_to_bit(input logic [1:0] f, input int p);
        if (f == 2'd1) return (p < WW) ? WW - 1 - p : -1;
        if (f == 2'd2) return (p >= SW - WW) ? SW - 1 - p : -1;
        return (p >= 1 && p <= WW) ? WW - p : -1;
    endfunction

    function automatic logic exp_lr(input logic [1:0] f, input int b);
        logic right;
        right = (b >= 32);
        return (f == 2'd1 || f == 2'd2) ? !right : right;
    endfunction

    function automatic logic [WW-1:0] src_word(input int line, input int ch, input int fr);
        logic [31:0] x;
        x = (32'(fr) * 32'd40503) ^ (32'(line) << 20) ^ (32'(ch) << 12) ^ 32'h5A5;
        x = x * 32'h9E3779B1;
        return x[31:8];
    endfunction

    function automatic logic [BUS-1:0] mk_tx(input int seed);
        logic [BUS-1:0] v;
        for (int i = 0; i < 6; i++) v[i*WW +: WW] = src_word(seed + 11, i, seed * 3);
        return v;
    endfunction

    function automatic logic [WW-1:0] exp_rx(input int pair, input int ch, input int fr);
        logic [WW-1:0] r;
        r = '0;
        for (int i = 2; i >= 0; i--)
            if (int'(route_sel[2*i +: 2]) == pair) r = src_word(i, ch, fr);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // model: count clocks since reset, latch format and transmit words at the frame boundary
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_n   <= 0;
            m_fmt <= 2'd0;
            m_tx  <= '0;
        end else begin
            m_n <= m_n + 1;
            if (((m_n + 1) % DIV == 0) && (((m_n + 1) / DIV) % 128 == 0)) begin
                m_fmt <= fmt_sel;
                m_tx  <= tx_word;
            end
        end
    end

    int          half_c, b_c, fr_c, p_c, k_c, fcap;
    logic        e_bit, e_val;
    logic [WW-1:0] wtmp;

    always @(negedge clk) begin
        half_c = m_n / DIV;
        b_c    = (half_c / 2) % 64;
        fr_c   = half_c / 128;
        p_c    = b_c % 32;
        k_c    = slot_to_bit(m_fmt, p_c);
        if (rst_n && !done_flag) begin
            chk(bclk == 1'((half_c % 2)), "R1 bclk", 64'(bclk), 64'(half_c % 2));
            chk(lrclk == exp_lr(m_fmt, b_c), "R2 R3 R6 lrclk", 64'(lrclk), 64'(exp_lr(m_fmt, b_c)));
            for (int j = 0; j < 3; j++) begin
                e_bit = (k_c < 0) ? 1'b0 : m_tx[j*48 + (b_c/32)*WW + k_c];
                chk(sdo[j] == e_bit, "R4 R6 R7 sdo", 64'(sdo[j]), 64'(e_bit));
            end
            e_val = (m_n >= 1) && ((m_n - 1) % DIV == 0) && (((m_n - 1) / DIV) % 128 == 127);
            chk(rx_valid == e_val, "R11 rx_valid", 64'(rx_valid), 64'(e_val));
            if (e_val) begin
                fcap = ((m_n - 1) / DIV) / 128;
                for (int j = 0; j < 3; j++)
                    for (int c = 0; c < 2; c++) begin
                        wtmp = exp_rx(j, c, fcap);
                        chk(rx_word[j*48 + c*WW +: WW] == wtmp, rx_tag,
                            64'(rx_word[j*48 + c*WW +: WW]), 64'(wtmp));
                    end
            end
        end
        // R5: drive each line per the frame format; filler 1 in empty slots must be ignored
        for (int i = 0; i < 3; i++) begin
            wtmp = src_word(i, b_c / 32, fr_c);
            sdi[i] = (k_c < 0) ? 1'b1 : wtmp[k_c];
        end
    end

    task automatic wait_mid();
        do @(negedge clk); while (((m_n / DIV) / 2) % 64 != 20);
    endtask

    initial begin
        tx_word = mk_tx(1);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(bclk == 1'b0, "R12 bclk", 64'(bclk), 0);
        chk(lrclk == 1'b0, "R12 lrclk", 64'(lrclk), 0);
        chk(sdo == 3'b000, "R12 sdo", 64'(sdo), 0);
        chk(rx_valid == 1'b0, "R12 rx_valid", 64'(rx_valid), 0);
        chk(rx_word == '0, "R12 rx_word", rx_word[63:0], 0);
        rst_n = 1'b1;
        // I2S, one-to-one routing; first frame sends zeros (R7)
        repeat (3 * FRAME_CLKS) @(negedge clk);
        // left-justified, rotated routing
        wait_mid();
        fmt_sel = 2'd1; route_sel = 6'b01_00_10; tx_word = mk_tx(2); rx_tag = "R6 R8";
        repeat (3 * FRAME_CLKS) @(negedge clk);
        // right-justified, two lines on centre pair, surround unassigned
        wait_mid();
        fmt_sel = 2'd2; route_sel = 6'b00_01_01; tx_word = mk_tx(3); rx_tag = "R9 R10";
        repeat (3 * FRAME_CLKS) @(negedge clk);
        // spare code behaves as I2S, nothing assigned
        wait_mid();
        fmt_sel = 2'd3; route_sel = 6'b11_11_11; tx_word = mk_tx(4); rx_tag = "R3 R9";
        repeat (2 * FRAME_CLKS) @(negedge clk);
        // back to left-justified with one-to-one routing
        wait_mid();
        fmt_sel = 2'd1; route_sel = 6'b10_01_00; tx_word = mk_tx(5); rx_tag = "R5 R8";
        repeat (2 * FRAME_CLKS) @(negedge clk);
        done_flag = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual running expected done");
            finish_run();
        end
    end

endmodule